// File: doc/BRIEF.md
# Load-Use Hazard Stall Controller

This block lives in the decode stage of an in-order pipeline. It looks for one hazard that forwarding cannot hide: a load in the execute stage whose destination register is read by the instruction now being decoded. The loaded value does not exist until the memory stage has finished, so no bypass path can deliver it in time.

When it finds this hazard, the controller holds the program counter and the fetch/decode register for one cycle. It also zeroes the control word that enters the decode/execute register, so a harmless bubble goes down the pipe. In the next cycle the load has moved to the memory stage and a bubble sits in execute, so the check no longer matches. The held instruction then re-issues, and the normal forwarding network supplies the loaded value from the write-back stage.

A flush request from branch resolution takes priority over the stall. The controller is purely combinational. Clock and reset are used only for the embedded checks.

Top module: `lus_stall_ctrl`

## Requirements
- R1: A hazard exists when `idex_mem_rd_i` is 1 and `idex_dst_i` equals the register number of any source whose valid bit is 1. Source g occupies bits [g*REG_W +: REG_W] of `ifid_src_i`, and its valid bit is `ifid_src_vld_i[g]`.
- R2: When there is a hazard and no flush, `pc_we_o` and `ifid_we_o` are both 0, and `ifid_clr_o` is 0.
- R3: When there is a hazard, `idex_ctrl_o` is 3'b000 and `idex_bubble_o` is 1. Control bit order is [2] register write, [1] memory read, [0] memory write.
- R4: A source whose valid bit is 0 never causes a stall, even if its register number matches the destination.
- R5: When `idex_mem_rd_i` is 0, nothing stalls, whatever the register numbers are. Non-load producers are left to forwarding.
- R6: With no hazard and no flush, `pc_we_o`=1, `ifid_we_o`=1, `ifid_clr_o`=0, `idex_bubble_o`=0, and `idex_ctrl_o` equals `dec_ctrl_i`.
- R7: When `flush_i`=1, whether or not a hazard exists: `pc_we_o`=1, `ifid_we_o`=1, `ifid_clr_o`=1, `idex_ctrl_o`=3'b000 and `idex_bubble_o`=1.
- R8: In a pipeline, a load followed directly by three dependent instructions costs exactly one bubble, and all results are correct.
- R9: In a pipeline, a load followed by an independent instruction and then a consumer costs no bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used by the embedded checks only) |
| rst_n | input | 1 | Synchronous active-low reset for the checks |
| flush_i | input | 1 | Branch-resolution flush request, highest priority |
| idex_mem_rd_i | input | 1 | Memory-read flag of the instruction in execute |
| idex_dst_i | input | REG_W | Destination register of the instruction in execute |
| ifid_src_i | input | NUM_SRC*REG_W | Packed source register numbers of the decoding instruction |
| ifid_src_vld_i | input | NUM_SRC | Per-source "actually read" flags |
| dec_ctrl_i | input | 3 | Decoded control word {reg write, mem read, mem write} |
| pc_we_o | output | 1 | Program counter write enable |
| ifid_we_o | output | 1 | Fetch/decode register write enable |
| ifid_clr_o | output | 1 | Clear fetch/decode register to a no-op |
| idex_ctrl_o | output | 3 | Control word entering decode/execute, zeroed on bubble |
| idex_bubble_o | output | 1 | High when a bubble is being inserted |

## Verification
The embedded properties check the output priority on every cycle: flush first, then stall, then pass-through. They also check that a masked source or a non-load producer can never raise a stall. What only the bench scenarios can show is the pipeline-level outcome. That means one bubble per load-use pair, no second stall for later consumers once forwarding takes over, no stall when an independent instruction sits between load and use, and correct final register values. The bench shows these by wrapping the controller in a small pipeline model with forwarding.

// File: rtl/lus_pkg.sv
// Package: shared types for the load-use stall controller.
// Assumes a three-bit pipeline control word in the order below.
package lus_pkg;
    // Control word carried from decode into the decode/execute register.
    typedef struct packed {
        logic reg_wr;   // bit 2
        logic mem_rd;   // bit 1
        logic mem_wr;   // bit 0
    } lus_ctrl_t;

    localparam int unsigned LUS_CTRL_W = $bits(lus_ctrl_t);
endpackage

// File: rtl/lus_src_cmp.sv
// Module: lus_src_cmp
// Compares one source register field against the producer destination.
// Assumes the valid flag is 1 only when the instruction really reads the field.
module lus_src_cmp #(
    parameter int unsigned REG_W = 5
) (
    input  logic [REG_W-1:0] src_i,
    input  logic             src_vld_i,
    input  logic [REG_W-1:0] dst_i,
    output logic             hit_o
);
    // Match only when the field is a real operand.
    assign hit_o = src_vld_i && (src_i == dst_i);
endmodule

// File: rtl/lus_hazard_detect.sv
// Module: lus_hazard_detect
// Builds one comparator per source and raises the hazard when a load is in execute.
// Assumes ld_pending_i is the memory-read flag of the execute-stage instruction.
module lus_hazard_detect #(
    parameter int unsigned REG_W   = 5,
    parameter int unsigned NUM_SRC = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld_pending_i,
    input  logic [REG_W-1:0]         dst_i,
    input  logic [NUM_SRC*REG_W-1:0] src_i,
    input  logic [NUM_SRC-1:0]       src_vld_i,
    output logic                     hazard_o
);
    logic [NUM_SRC-1:0] hit_vec;

    // One comparator for every source operand.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
        lus_src_cmp #(.REG_W(REG_W)) cmp_i (
            .src_i    (src_i[g*REG_W +: REG_W]),
            .src_vld_i(src_vld_i[g]),
            .dst_i    (dst_i),
            .hit_o    (hit_vec[g])
        );

        AST_MASKED_SRC: assert property (@(posedge clk) disable iff (!rst_n)
            hit_vec[g] |-> src_vld_i[g]); // R4
    end

    // A stall is needed only for a load producer whose result some operand reads.
    assign hazard_o = ld_pending_i && (|hit_vec);

    AST_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_pending_i |-> !hazard_o); // R5
endmodule

// File: rtl/lus_pipe_ctrl.sv
// Module: lus_pipe_ctrl
// Turns hazard and flush into PC / IF-ID enables and the gated control word.
// Assumes a flush redirects the PC elsewhere, so the PC must still be written.
module lus_pipe_ctrl
    import lus_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hazard_i,
    input  logic      flush_i,
    input  lus_ctrl_t dec_ctrl_i,
    output logic      pc_we_o,
    output logic      ifid_we_o,
    output logic      ifid_clr_o,
    output lus_ctrl_t idex_ctrl_o,
    output logic      idex_bubble_o
);
    // Priority select: flush, then load-use stall, then normal flow.
    always_comb begin
        pc_we_o       = 1'b1;
        ifid_we_o     = 1'b1;
        ifid_clr_o    = 1'b0;
        idex_ctrl_o   = dec_ctrl_i;
        idex_bubble_o = 1'b0;
        if (flush_i) begin
            ifid_clr_o    = 1'b1;
            idex_ctrl_o   = '0;
            idex_bubble_o = 1'b1;
        end else if (hazard_i) begin
            pc_we_o       = 1'b0;
            ifid_we_o     = 1'b0;
            idex_ctrl_o   = '0;
            idex_bubble_o = 1'b1;
        end
    end

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (hazard_i && !flush_i) |-> (!pc_we_o && !ifid_we_o && !ifid_clr_o)); // R2
    AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        hazard_i |-> (idex_ctrl_o == '0 && idex_bubble_o)); // R3
    AST_RUN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!hazard_i && !flush_i) |-> (pc_we_o && ifid_we_o && !ifid_clr_o
                                     && !idex_bubble_o && idex_ctrl_o == dec_ctrl_i)); // R6
    AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |-> (pc_we_o && ifid_we_o && ifid_clr_o && idex_ctrl_o == '0)); // R7
endmodule

// File: rtl/lus_stall_ctrl.sv
// Module: lus_stall_ctrl (top)
// Decode-stage load-use stall controller: one bubble per load-use pair.
// Assumes the decode/execute register loads idex_ctrl_o every cycle and that
// forwarding from write-back serves the consumer after the bubble. Holds no state.
module lus_stall_ctrl
    import lus_pkg::*;
#(
    parameter int unsigned REG_W   = 5,
    parameter int unsigned NUM_SRC = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush_i,
    input  logic                     idex_mem_rd_i,
    input  logic [REG_W-1:0]         idex_dst_i,
    input  logic [NUM_SRC*REG_W-1:0] ifid_src_i,
    input  logic [NUM_SRC-1:0]       ifid_src_vld_i,
    input  logic [LUS_CTRL_W-1:0]    dec_ctrl_i,
    output logic                     pc_we_o,
    output logic                     ifid_we_o,
    output logic                     ifid_clr_o,
    output logic [LUS_CTRL_W-1:0]    idex_ctrl_o,
    output logic                     idex_bubble_o
);
    logic      hazard;
    lus_ctrl_t ctrl_out;

    // Hazard detection across all source operands.
    lus_hazard_detect #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) det_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_pending_i(idex_mem_rd_i),
        .dst_i       (idex_dst_i),
        .src_i       (ifid_src_i),
        .src_vld_i   (ifid_src_vld_i),
        .hazard_o    (hazard)
    );

    // Enable and control-gating generation.
    lus_pipe_ctrl ctl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .hazard_i     (hazard),
        .flush_i      (flush_i),
        .dec_ctrl_i   (lus_ctrl_t'(dec_ctrl_i)),
        .pc_we_o      (pc_we_o),
        .ifid_we_o    (ifid_we_o),
        .ifid_clr_o   (ifid_clr_o),
        .idex_ctrl_o  (ctrl_out),
        .idex_bubble_o(idex_bubble_o)
    );

    assign idex_ctrl_o = ctrl_out;

    AST_DETECT_SRC0: assert property (@(posedge clk) disable iff (!rst_n)
        (idex_mem_rd_i && ifid_src_vld_i[0] && ifid_src_i[REG_W-1:0] == idex_dst_i)
        |-> (idex_bubble_o && (flush_i || !pc_we_o))); // R1
endmodule

// File: tb/lus_stall_ctrl_tb_top.sv
// Bench: a scoreboard for directed port checks, then a small pipeline model
// with forwarding that runs short programs through the controller.
module lus_stall_ctrl_tb_top;
    localparam int RW = 5;
    localparam int NS = 2;
    localparam logic [1:0] OP_NOP = 2'd0, OP_LD = 2'd1, OP_ADD = 2'd2;

    typedef struct packed { logic [1:0] op; logic [4:0] rd, rs1, rs2; } ins_t;
    typedef struct { logic pc_we, ifid_we, ifid_clr; logic [2:0] ctl; logic bub; string req; } exp_t;

    logic clk = 0, rst_n = 0;
    always #10 clk = ~clk;

    int errors = 0, checks = 0;
    bit done = 0, pipe_mode = 0, model_rst = 0;
    exp_t q[$];

    // directed drive values
    logic d_flush = 0, d_mrd = 0;
    logic [RW-1:0] d_dst = '0;
    logic [NS*RW-1:0] d_src = '0;
    logic [NS-1:0] d_vld = '0;
    logic [2:0] d_ctl = '0;

    // pipeline model state
    ins_t prog[8];
    int prog_len, pc, bubbles;
    ins_t ifid, idex;
    logic [2:0] idex_ctl;
    logic xm_wr, xm_rdm, mw_wr;
    logic [4:0] xm_rd, mw_rd;
    logic [31:0] xm_val, mw_val;
    logic [31:0] rf[32];
    logic [31:0] dmem[8];

    logic [2:0] m_dec;
    logic [1:0] m_vld;
    assign m_dec = (ifid.op == OP_LD) ? 3'b110 : (ifid.op == OP_ADD) ? 3'b100 : 3'b000;
    assign m_vld = (ifid.op == OP_LD) ? 2'b01 : (ifid.op == OP_ADD) ? 2'b11 : 2'b00;

    logic pc_we, ifid_we, ifid_clr, bub;
    logic [2:0] ctl_o;

    lus_stall_ctrl #(.REG_W(RW), .NUM_SRC(NS)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .flush_i(pipe_mode ? 1'b0 : d_flush),
        .idex_mem_rd_i(pipe_mode ? idex_ctl[1] : d_mrd),
        .idex_dst_i(pipe_mode ? idex.rd : d_dst),
        .ifid_src_i(pipe_mode ? {ifid.rs2, ifid.rs1} : d_src),
        .ifid_src_vld_i(pipe_mode ? m_vld : d_vld),
        .dec_ctrl_i(pipe_mode ? m_dec : d_ctl),
        .pc_we_o(pc_we), .ifid_we_o(ifid_we), .ifid_clr_o(ifid_clr),
        .idex_ctrl_o(ctl_o), .idex_bubble_o(bub)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: apply one input set and push the expected outputs from the requirements.
    task automatic drive(input string req, input logic fl, input logic mrd, input logic [4:0] dst,
                         input logic [4:0] s0, input logic [4:0] s1, input logic [1:0] vld,
                         input logic [2:0] ctl);
        exp_t e;
        logic hz;
        @(posedge clk); #1;
        d_flush = fl; d_mrd = mrd; d_dst = dst; d_src = {s1, s0}; d_vld = vld; d_ctl = ctl;
        hz = mrd && ((vld[0] && s0 == dst) || (vld[1] && s1 == dst));
        e.req = req;
        if (fl)      begin e.pc_we = 1; e.ifid_we = 1; e.ifid_clr = 1; e.ctl = 0;   e.bub = 1; end
        else if (hz) begin e.pc_we = 0; e.ifid_we = 0; e.ifid_clr = 0; e.ctl = 0;   e.bub = 1; end
        else         begin e.pc_we = 1; e.ifid_we = 1; e.ifid_clr = 0; e.ctl = ctl; e.bub = 0; end
        q.push_back(e);
    endtask

    // Monitor: compare outputs at the falling edge against the queued expectation.
    always @(negedge clk) begin
        if (!pipe_mode && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.req, {25'd0, pc_we, ifid_we, ifid_clr, ctl_o, bub},
                       {25'd0, e.pc_we, e.ifid_we, e.ifid_clr, e.ctl, e.bub});
        end
    end

    function automatic logic [31:0] fwd(input logic [4:0] r);
        if (xm_wr && !xm_rdm && xm_rd == r) return xm_val;
        if (mw_wr && mw_rd == r) return mw_val;
        return rf[r];
    endfunction

    // Pipeline model: IF, ID (controller), EX with forwarding, MEM, WB.
    always @(posedge clk) begin
        logic [31:0] a, b;
        if (model_rst) begin
            pc <= 0; bubbles <= 0; ifid <= '0; idex <= '0; idex_ctl <= '0;
            xm_wr <= 0; xm_rdm <= 0; xm_rd <= '0; xm_val <= '0;
            mw_wr <= 0; mw_rd <= '0; mw_val <= '0;
            for (int i = 0; i < 32; i++) rf[i] <= 32'(i);
            for (int i = 0; i < 8; i++) dmem[i] <= 32'd0;
            rf[1] <= 32'd3; rf[5] <= 32'd1; rf[6] <= 32'd2; dmem[3] <= 32'd40;
        end else if (pipe_mode) begin
            a = fwd(idex.rs1);
            b = fwd(idex.rs2);
            if (mw_wr) rf[mw_rd] <= mw_val;
            mw_wr <= xm_wr; mw_rd <= xm_rd;
            mw_val <= xm_rdm ? dmem[xm_val[2:0]] : xm_val;
            xm_wr <= idex_ctl[2]; xm_rdm <= idex_ctl[1]; xm_rd <= idex.rd;
            xm_val <= (idex.op == OP_LD) ? a : a + b;
            idex <= ifid; idex_ctl <= ctl_o;
            if (ifid_clr) ifid <= '0;
            else if (ifid_we) ifid <= (pc < prog_len) ? prog[pc] : '0;
            if (pc_we) pc <= pc + 1;
            if (bub) bubbles <= bubbles + 1;
        end
    end

    task automatic run_prog(input int cycles);
        @(posedge clk); #1; model_rst = 1; pipe_mode = 1;
        @(posedge clk); #1; model_rst = 0;
        repeat (cycles) @(posedge clk);
        #1; pipe_mode = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1; rst_n = 1;
        // reset state: idle inputs pass through
        drive("R6 reset", 0, 0, 5'd0, 5'd0, 5'd0, 2'b00, 3'b000);
        drive("R1 src0 match", 0, 1, 5'd2, 5'd2, 5'd7, 2'b11, 3'b100);
        drive("R2 src1 match", 0, 1, 5'd9, 5'd4, 5'd9, 2'b11, 3'b100);
        drive("R3 both match", 0, 1, 5'd3, 5'd3, 5'd3, 2'b11, 3'b111);
        drive("R6 no match", 0, 1, 5'd8, 5'd1, 5'd2, 2'b11, 3'b101);
        drive("R4 src1 masked", 0, 1, 5'd9, 5'd4, 5'd9, 2'b01, 3'b100);
        drive("R4 src0 masked", 0, 1, 5'd4, 5'd4, 5'd9, 2'b10, 3'b010);
        drive("R5 non-load match", 0, 0, 5'd2, 5'd2, 5'd2, 2'b11, 3'b100);
        drive("R7 flush with hazard", 1, 1, 5'd2, 5'd2, 5'd0, 2'b01, 3'b110);
        drive("R7 flush alone", 1, 0, 5'd0, 5'd1, 5'd2, 2'b11, 3'b100);
        drive("R1 max reg", 0, 1, 5'd31, 5'd0, 5'd31, 2'b10, 3'b001);
        drive("R6 pass ctrl", 0, 0, 5'd0, 5'd0, 5'd0, 2'b00, 3'b111);
        wait (q.size() == 0);
        @(negedge clk);

        // R8: load then three consumers
        prog[0] = '{OP_LD,  5'd2, 5'd1, 5'd0};
        prog[1] = '{OP_ADD, 5'd4, 5'd2, 5'd5};
        prog[2] = '{OP_ADD, 5'd8, 5'd2, 5'd6};
        prog[3] = '{OP_ADD, 5'd9, 5'd4, 5'd2};
        prog_len = 4;
        run_prog(12);
        chk("R8 bubble count", 32'(bubbles), 32'd1);
        chk("R8 r2", rf[2], 32'd40);
        chk("R8 r4", rf[4], 32'd41);
        chk("R8 r8", rf[8], 32'd42);
        chk("R8 r9", rf[9], 32'd81);

        // R9: independent instruction between load and use
        prog[0] = '{OP_LD,  5'd2, 5'd1, 5'd0};
        prog[1] = '{OP_ADD, 5'd7, 5'd5, 5'd6};
        prog[2] = '{OP_ADD, 5'd4, 5'd2, 5'd5};
        prog_len = 3;
        run_prog(12);
        chk("R9 bubble count", 32'(bubbles), 32'd0);
        chk("R9 r7", rf[7], 32'd3);
        chk("R9 r4", rf[4], 32'd41);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule